// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte control register reached through a simple I/O port at address 0xCF9. Firmware uses it to start a platform reset. A write with the trigger bit (bit 2) set raises a one-cycle request toward the platform's reset sequencer, and the stored byte is left as it was. Any other write to the port keeps only the reset-type bit (bit 1) and drops every other bit.

Reads of the port return the stored byte one cycle after the read strobe, together with a valid flag. A status output stays high while the stored byte is nonzero. The sequencer uses it to know that a reset type has been chosen and must be kept. Every other I/O address is ignored. The register clears on a synchronous, active-high reset.

Top module: `rcr_reset_ctl`

## Requirements
- R1: While reset is high and after it is released, `sys_reset_req`, `reset_kind_held` and `io_rvalid` are 0, and a read of 0xCF9 returns 0x00.
- R2: A write to 0xCF9 whose data has bit 2 set drives `sys_reset_req` high for exactly the one cycle that follows the write strobe. No other access raises it.
- R3: A write to 0xCF9 with bit 2 set leaves the stored byte unchanged.
- R4: A write to 0xCF9 with bit 2 clear stores the written data ANDed with 0x02, so only bit 1 can ever read back as 1.
- R5: A read strobe at 0xCF9 gives `io_rvalid` = 1 and `io_rdata` = the stored byte in the next cycle.
- R6: An access to any address other than 0xCF9 has no effect: writes change nothing and raise no request, and reads give `io_rvalid` = 0 and `io_rdata` = 0x00 in the next cycle.
- R7: `reset_kind_held` is 1 exactly when the stored byte is nonzero, and it follows every write to the port from the cycle after that write.
- R8: When a read and a write to 0xCF9 happen in the same cycle, the read returns the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_rdata | output | 8 | Read data, registered |
| io_rvalid | output | 1 | High in the cycle after a read of this port |
| sys_reset_req | output | 1 | One-cycle platform reset request |
| reset_kind_held | output | 1 | Stored byte is nonzero |

## Verification
The assertions assume that each strobe marks one access per cycle. They also assume that address and data are valid whenever a strobe is high. The properties that tie the request pulse to a preceding trigger write depend on that one-strobe-per-access model. The bench drives every strobe for exactly one cycle, with address and data changed only on the falling edge. It sweeps all 256 data values at the port, and it sends trigger and type patterns to several nearby addresses that must not decode.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

    localparam int unsigned RCR_ADDR_W   = 16;
    localparam int unsigned RCR_DATA_W   = 8;
    localparam logic [15:0] RCR_PORT     = 16'h0CF9;
    localparam int unsigned RCR_TRIG_BIT = 2;
    localparam int unsigned RCR_TYPE_BIT = 1;

    // Decoded view of one bus cycle
    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
        logic trigger;
    } rcr_access_t;

    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_STORE = 2'd1,
        WR_RESET = 2'd2
    } rcr_wr_kind_e;

    function automatic rcr_wr_kind_e rcr_classify(input rcr_access_t acc);
        if (!acc.wr_hit)     return WR_NONE;
        else if (acc.trigger) return WR_RESET;
        else                 return WR_STORE;
    endfunction

endpackage

// File: rtl/rcr_addr_decode.sv
module rcr_addr_decode
    import rcr_pkg::*;
#(
    parameter int unsigned ADDR_W   = RCR_ADDR_W,
    parameter int unsigned DATA_W   = RCR_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(RCR_PORT),
    parameter int unsigned TRIG_BIT = RCR_TRIG_BIT
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output rcr_access_t       acc
);
    logic hit;

    assign hit         = (addr == PORT_ADDR);
    assign acc.wr_hit  = wr && hit;
    assign acc.rd_hit  = rd && hit;
    assign acc.trigger = wdata[TRIG_BIT];
endmodule

// File: rtl/rcr_store.sv
module rcr_store
    import rcr_pkg::*;
#(
    parameter int unsigned DATA_W   = RCR_DATA_W,
    parameter int unsigned TYPE_BIT = RCR_TYPE_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  rcr_access_t       acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored,
    output logic              reset_req
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

    rcr_wr_kind_e kind;
    assign kind = rcr_classify(acc);

    always_ff @(posedge clk) begin
        if (rst) begin
            stored    <= '0;
            reset_req <= 1'b0;
        end else begin
            reset_req <= (kind == WR_RESET);
            if (kind == WR_STORE)
                stored <= wdata & KEEP_MASK;
        end
    end

    p_req_after_trig_r2: assert property (@(posedge clk) disable iff (rst)
        (acc.wr_hit && acc.trigger) |=> reset_req);
    p_req_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $past(acc.wr_hit && acc.trigger));
    p_trig_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (acc.wr_hit && acc.trigger) |=> $stable(stored));
    p_store_masked_r4: assert property (@(posedge clk) disable iff (rst)
        (acc.wr_hit && !acc.trigger) |=> (stored == ($past(wdata) & KEEP_MASK)));
    p_only_type_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (stored & ~KEEP_MASK) == '0);
endmodule

// File: rtl/rcr_read_port.sv
module rcr_read_port
    import rcr_pkg::*;
#(
    parameter int unsigned DATA_W = RCR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  rcr_access_t       acc,
    input  logic [DATA_W-1:0] stored,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= acc.rd_hit;
            rdata  <= acc.rd_hit ? stored : '0;
        end
    end

    p_rd_returns_r5: assert property (@(posedge clk) disable iff (rst)
        acc.rd_hit |=> (rvalid && rdata == $past(stored)));
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));
endmodule

// File: rtl/rcr_reset_ctl.sv
module rcr_reset_ctl
    import rcr_pkg::*;
#(
    parameter int unsigned ADDR_W   = RCR_ADDR_W,
    parameter int unsigned DATA_W   = RCR_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(RCR_PORT),
    parameter int unsigned TRIG_BIT = RCR_TRIG_BIT,
    parameter int unsigned TYPE_BIT = RCR_TYPE_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rvalid,
    output logic              sys_reset_req,
    output logic              reset_kind_held
);
    rcr_access_t       acc;
    logic [DATA_W-1:0] stored;

    rcr_addr_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PORT_ADDR(PORT_ADDR), .TRIG_BIT(TRIG_BIT)
    ) u_decode (
        .addr(io_addr), .wdata(io_wdata), .wr(io_wr), .rd(io_rd), .acc(acc)
    );

    rcr_store #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_store (
        .clk(clk), .rst(rst), .acc(acc), .wdata(io_wdata),
        .stored(stored), .reset_req(sys_reset_req)
    );

    rcr_read_port #(.DATA_W(DATA_W)) u_read (
        .clk(clk), .rst(rst), .acc(acc), .stored(stored),
        .rdata(io_rdata), .rvalid(io_rvalid)
    );

    assign reset_kind_held = |stored;

    p_foreign_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr != PORT_ADDR) |=> ($stable(stored) && !sys_reset_req));
    p_foreign_rd_r6: assert property (@(posedge clk) disable iff (rst)
        !(io_rd && io_addr == PORT_ADDR) |=> !io_rvalid);
    p_flag_tracks_r7: assert property (@(posedge clk) disable iff (rst)
        io_rvalid |-> ((io_rdata != '0) == $past(reset_kind_held)));
    p_rd_before_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_wr && io_addr == PORT_ADDR) |=> (io_rdata == $past(stored)));
endmodule

// File: tb/rcr_reset_ctl_tb_top.sv
module rcr_reset_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] PORT = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic        sys_reset_req;
    logic        reset_kind_held;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcr_reset_ctl dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .sys_reset_req(sys_reset_req), .reset_kind_held(reset_kind_held)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("R1 watchdog", 32'd0, 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 req in reset", sys_reset_req, 0);
        chk("R1 flag in reset", reset_kind_held, 0);
        chk("R1 rvalid in reset", io_rvalid, 0);
        rst = 1'b0;
        do_read(PORT);
        chk("R1 rvalid after reset", io_rvalid, 1);
        chk("R1 rdata after reset", io_rdata, 8'h00);

        // Sweep of every write value at the port
        for (int v = 0; v < 256; v++) begin
            do_write(PORT, 8'(v));
            chk("R2 request pulse", sys_reset_req, 32'(v[2]));
            if (!v[2]) model = 8'(v) & 8'h02;   // R4 masking, else R3 hold
            chk("R7 flag", reset_kind_held, 32'(model != 0));
            @(negedge clk);
            chk("R2 pulse one cycle", sys_reset_req, 0);
            do_read(PORT);
            chk("R5 rvalid", io_rvalid, 1);
            chk(v[2] ? "R3 unchanged" : "R4 stored", io_rdata, model);
        end

        // R6: foreign addresses
        do_write(PORT, 8'h02); model = 8'h02;
        for (int i = 0; i < 6; i++) begin
            logic [15:0] a;
            case (i)
                0: a = 16'h0CF8; 1: a = 16'h0CFA; 2: a = 16'h0CF1;
                3: a = 16'h1CF9; 4: a = 16'h0000; default: a = 16'hFFFF;
            endcase
            do_write(a, 8'h04);
            chk("R6 no request", sys_reset_req, 0);
            do_write(a, 8'h00);
            chk("R6 flag kept", reset_kind_held, 1);
            do_read(a);
            chk("R6 rvalid low", io_rvalid, 0);
            chk("R6 rdata zero", io_rdata, 8'h00);
            do_read(PORT);
            chk("R6 port unchanged", io_rdata, model);
        end

        // R8: read and write together
        @(negedge clk);
        io_addr = PORT; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("R8 old value", io_rdata, 8'h02);
        chk("R7 flag cleared", reset_kind_held, 0);
        model = 8'h00;
        do_read(PORT);
        chk("R8 new value", io_rdata, 8'h00);

        @(negedge clk);
        io_addr = PORT; io_wdata = 8'h06; io_wr = 1'b1; io_rd = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0;
        chk("R8 trigger read", io_rdata, 8'h00);
        chk("R2 trigger with read", sys_reset_req, 1);

        // R1: reset clears a held type
        do_write(PORT, 8'hFA);
        chk("R4 type set", reset_kind_held, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 flag cleared", reset_kind_held, 0);
        do_read(PORT);
        chk("R1 cleared by reset", io_rdata, 8'h00);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule